// File: doc/BRIEF.md
# Serial Presence-Detect Configuration Memory Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data, both open-drain). It gives a host controller read and write access to a 256-byte array that holds module configuration data. The block runs on a fast system clock. It passes both bus lines through two-flop synchronisers and finds SCL and SDA edges in that clock domain. It pulls SDA low through a single output-enable signal and never drives the line high.

A host begins every command with a start condition and then sends a seven-bit slave address plus a direction bit. The upper four address bits are fixed at 1010 and the lower three bits come from strap inputs. A write command then loads an 8-bit word pointer and may store any number of data bytes. A read command sends bytes from the pointer, one after another, for as long as the host acknowledges each one. A repeated start sets up a random read: a write command that carries only the pointer, followed by a read command. A stop condition ends the transfer and puts the slave into standby. A standby output shows this state.

Top module: `spd_eeprom_slave`

## Requirements
- R1: After synchronous reset, `standby` is 1 and `sda_oe` is 0.
- R2: After a start condition (SDA falls while SCL is high), the slave pulls SDA low during the ninth SCL clock when the first byte is 1010 followed by `strap[2:0]` and a direction bit. That byte is sent MSB first and the direction bit is the LSB, where 0 means write and 1 means read.
- R3: If the address does not match, the slave gives no acknowledge and keeps SDA released for all later clocks until the next start condition.
- R4: In a write command, the first byte after the address loads the word pointer. Each later byte is stored at the pointer and the pointer then advances. The slave acknowledges every one of these bytes.
- R5: The pointer wraps from 255 to 0, for both writes and reads.
- R6: In a read command, the slave sends the byte at the pointer MSB first and then releases SDA for the ninth clock. Whenever the host acknowledges, the slave sends the next byte. Each byte sent advances the pointer, so a read that sends no pointer continues from where the last access stopped.
- R7: If the host does not acknowledge a read byte, the slave stops driving and stays released through any further clocks until a stop or start condition.
- R8: A stop condition (SDA rises while SCL is high) sets `standby` and releases SDA. A start condition clears `standby`.
- R9: `sda_oe` changes only after a detected falling edge of SCL, or after a start or stop condition, so it is stable while SCL is high.
- R10: A repeated start in the middle of a command restarts the address phase. A pointer write followed by a repeated start and a read address reads from that pointer.
- R11: Before the first start condition, clocked bus activity is ignored. A matching address byte sent without a start gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level from the pad |
| sda_in | input | 1 | SDA line level from the pad |
| strap | input | 3 | Low three bits of the slave address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| standby | output | 1 | 1 while in standby after reset or a stop |

## Verification
The checker tests the rules that hold on every cycle. These are the state after reset, that the output enable moves only after an SCL falling edge or a bus condition, that a stop forces standby with SDA released, that a start leaves standby, and that the slave is quiet while in standby. The bench scenarios cover the rules that span a whole command. These are address matching against the strap inputs, stored data returned on later reads, pointer advance and wrap across 255, the continue or stop decision taken from the host's acknowledge, random reads through a repeated start, and traffic ignored before any start.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_PTR,
    ST_ACK_PTR,
    ST_WDAT,
    ST_ACK_WDAT,
    ST_RDAT,
    ST_RACK,
    ST_WAIT
  } spd_state_e;
endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
  assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/spd_mem.sv
module spd_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import spd_pkg::*;
#(
  parameter int AW     = 8,
  parameter int STRAPW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [STRAPW-1:0] strap,
  input  logic [7:0]        rd_data,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              sda_oe,
  output logic              standby
);
  spd_state_e    state;
  logic [3:0]    cnt;
  logic [7:0]    rx_sh;
  logic [7:0]    tx_sh;
  logic [AW-1:0] ptr;
  logic          dir_rd;
  logic          host_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      dir_rd   <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      standby  <= 1'b1;
      mem_we   <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (stop_det) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        standby <= 1'b1;
      end else if (start_det) begin
        state   <= ST_DEV;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        standby <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_PTR, ST_WDAT: begin
            if (scl_rise && cnt != 4'd8) begin
              rx_sh <= {rx_sh[6:0], sda_lvl};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == ST_DEV) begin
                if (rx_sh[7:1] == {DEV_TYPE, strap}) begin
                  dir_rd <= rx_sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ACK_DEV;
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_PTR) begin
                ptr    <= rx_sh[AW-1:0];
                sda_oe <= 1'b1;
                state  <= ST_ACK_PTR;
              end else begin
                mem_we <= 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_ACK_WDAT;
              end
            end
          end
          ST_ACK_DEV: if (scl_fall) begin
            if (dir_rd) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
              cnt    <= '0;
              state  <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_PTR;
            end
          end
          ST_ACK_PTR: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDAT;
          end
          ST_ACK_WDAT: if (scl_fall) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
            state  <= ST_WDAT;
          end
          ST_RDAT: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe   <= 1'b0;
              ptr      <= ptr + 1'b1;
              host_ack <= 1'b0;
              state    <= ST_RACK;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
              cnt    <= cnt + 4'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise) host_ack <= ~sda_lvl;
            else if (scl_fall) begin
              if (host_ack) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[7];
                cnt    <= '0;
                state  <= ST_RDAT;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mem_addr  = ptr;
  assign mem_wdata = rx_sh;
endmodule

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave #(
  parameter int AW        = 8,
  parameter int STRAPW    = 3,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [STRAPW-1:0] strap,
  output logic              sda_oe,
  output logic              standby
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, rd_data;

  spd_line_sync #(.STAGES(SYNC_STGS)) scl_sync_i (
    .clk(clk), .rst(rst), .line_in(scl_in),
    .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
  );

  spd_line_sync #(.STAGES(SYNC_STGS)) sda_sync_i (
    .clk(clk), .rst(rst), .line_in(sda_in),
    .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
  );

  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;

  spd_ctrl #(.AW(AW), .STRAPW(STRAPW)) ctrl_i (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det), .strap(strap),
    .rd_data(rd_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .sda_oe(sda_oe), .standby(standby)
  );

  spd_mem #(.AW(AW), .DW(8)) mem_i (
    .clk(clk), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(rd_data)
  );
endmodule

// File: rtl/spd_eeprom_checker.sv
module spd_eeprom_checker (
  input logic clk,
  input logic rst,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic standby
);
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (standby && !sda_oe));

  p_oe_timing_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  p_stop_standby_r8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (standby && !sda_oe));

  p_start_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (start_det && !stop_det) |=> (!standby && !sda_oe));

  p_standby_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    standby |-> !sda_oe);
endmodule

bind spd_eeprom_slave spd_eeprom_checker chk_i (
  .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .standby(standby)
);

// File: tb/spd_eeprom_slave_tb_top.sv
module spd_eeprom_slave_tb_top;
  localparam int Q = 4;
  localparam logic [2:0] MY_STRAP = 3'b101;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, standby;
  wire  sda_line = !(m_low || sda_oe);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] model [256];
  bit         valid [256];
  int         mptr = 0;

  spd_eeprom_slave dut_i (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .strap(MY_STRAP), .sda_oe(sda_oe), .standby(standby)
  );

  function automatic logic [7:0] dev_byte(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_xfer(input bit drive_low, output bit smp, output bit moved);
    logic a;
    m_low = drive_low;
    wait_q();
    scl_m = 1'b1;
    wait_q();
    smp = sda_line;
    a = sda_oe;
    wait_q();
    moved = (a != sda_oe);
    scl_m = 1'b0;
    wait_q();
  endtask

  task automatic bus_start();
    m_low = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    m_low = 1'b1; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    m_low = 1'b0; wait_q();
    wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s, mv;
    bit any_mv = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(!b[i], s, mv);
      any_mv |= mv;
    end
    bit_xfer(1'b0, s, mv);
    any_mv |= mv;
    ack = !s;
    chk(!any_mv, "R9 oe stable while SCL high (send)", any_mv, 0);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    bit s, mv;
    bit any_mv = 0;
    for (int i = 0; i < 8; i++) begin
      bit_xfer(1'b0, s, mv);
      b = {b[6:0], s};
      any_mv |= mv;
    end
    bit_xfer(give_ack, s, mv);
    any_mv |= mv;
    chk(!any_mv, "R9 oe stable while SCL high (recv)", any_mv, 0);
  endtask

  task automatic do_write(input int addr, input int n);
    bit ack;
    logic [7:0] d;
    bus_start();
    chk(!standby, "R8 start clears standby", standby, 0);
    send_byte(dev_byte(MY_STRAP, 1'b0), ack);
    chk(ack, "R2 write address ack", ack, 1);
    send_byte(addr[7:0], ack);
    chk(ack, "R4 pointer ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom_range(0, 255));
      send_byte(d, ack);
      chk(ack, "R4 data ack", ack, 1);
      model[(addr + i) % 256] = d;
      valid[(addr + i) % 256] = 1'b1;
    end
    bus_stop();
    chk(standby, "R8 stop sets standby", standby, 1);
    mptr = (addr + n) % 256;
  endtask

  task automatic do_read(input int addr, input int n, input bit set_ptr);
    bit ack;
    logic [7:0] d;
    bus_start();
    if (set_ptr) begin
      send_byte(dev_byte(MY_STRAP, 1'b0), ack);
      chk(ack, "R10 dummy write ack", ack, 1);
      send_byte(addr[7:0], ack);
      chk(ack, "R10 pointer ack", ack, 1);
      bus_start();
      mptr = addr;
    end
    send_byte(dev_byte(MY_STRAP, 1'b1), ack);
    chk(ack, "R2 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      if (valid[mptr]) chk(d == model[mptr], "R6 R5 read data", d, model[mptr]);
      mptr = (mptr + 1) % 256;
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) valid[i] = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(standby && !sda_oe, "R1 reset state", {standby, sda_oe}, 2);

    // R11: address clocked without any start condition
    scl_m = 1'b0; wait_q();
    send_byte(dev_byte(MY_STRAP, 1'b0), ack);
    chk(!ack, "R11 no ack without start", ack, 0);
    chk(standby, "R11 standby kept", standby, 1);
    m_low = 1'b0; wait_q(); scl_m = 1'b1; wait_q();

    // R3: address mismatch
    bus_start();
    send_byte(dev_byte(3'b000, 1'b0), ack);
    chk(!ack, "R3 mismatch no ack", ack, 0);
    send_byte(8'h00, ack);
    chk(!ack, "R3 silent after mismatch", ack, 0);
    bus_stop();

    // R4/R6 basic write and random read
    do_write(16, 4);
    do_read(16, 4, 1'b1);

    // R5 wrap on write and read
    do_write(254, 4);
    do_read(255, 3, 1'b1);

    // R6 current-address read continues from pointer
    do_write(100, 3);
    do_read(0, 1, 1'b1);
    do_read(0, 2, 1'b0);

    // R7: host nack then extra clocks stay released
    do_read(16, 2, 1'b1);
    bus_start();
    send_byte(dev_byte(MY_STRAP, 1'b1), ack);
    recv_byte(1'b0, d);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R7 released after nack", d, 8'hFF);
    bus_stop();
    chk(standby, "R7 R8 standby after stop", standby, 1);

    // randomized traffic
    for (int k = 0; k < 24; k++) begin
      int a = $urandom_range(0, 255);
      int n = $urandom_range(1, 6);
      if ($urandom_range(0, 1) == 0) do_write(a, n);
      else do_read(a, n, 1'b1);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule